// File: doc/BRIEF.md
# Predicted-Miss Read Bypass Controller

This block sits on the read path in front of a last-level cache and decides, for each request, whether the tag store lookup can be skipped. A miss predictor runs per thread. It counts read lookups and read misses on a small group of sampled sets over epochs of fixed length. When a thread's sampled miss rate in one epoch is above a threshold percentage, every read from that thread in the next epoch is predicted to miss.

A predicted-miss read to a set that is not sampled is not sent straight to memory. The controller first asks an external dirty tracker whether the block is dirty. A dirty block still goes to the tag store, because the cache holds the only current copy. A clean block is forwarded to the next level with no tag lookup. The controller therefore stays correct under a writeback policy without needing a predictor that is never wrong.

Writes and writebacks always go to the tag store and never change the predictor. Reads to sampled sets always go to the tag store, so measurement continues while a thread is being bypassed. The routing decision is combinational and is made in the cycle the request is presented. The tracker answer `dirty_hit` is expected back in that same cycle.

Top module: `rd_bypass_ctrl`

## Requirements
- R1: While `rst_n` is low, all bits of `bypass_flags` are 0 and neither `fwd_next` nor `dirty_query` is asserted. Each valid request is routed to `tag_lookup`.
- R2: A valid read whose thread flag (`bypass_flags[req_thread]`) is 0 asserts `tag_lookup` and does not assert `dirty_query` or `fwd_next`.
- R3: A valid read whose thread flag is 1, to a set that is not sampled, asserts `dirty_query` in the same cycle. If `dirty_hit` is 1, `tag_lookup` is asserted and `fwd_next` is not. If `dirty_hit` is 0, `fwd_next` is asserted and `tag_lookup` is not.
- R4: A set is sampled when its low `SAMP_BITS` index bits are all zero. A read to a sampled set never asserts `dirty_query` or `fwd_next`, whatever its thread flag.
- R5: A valid write (`req_read` = 0) always asserts `tag_lookup` and never asserts `dirty_query` or `fwd_next`.
- R6: An epoch lasts `EPOCH_LEN` cycles. The first epoch starts in the first cycle after reset is released. `bypass_flags` changes only at the clock edge that ends an epoch.
- R7: At the end of an epoch, thread t's flag becomes 1 exactly when misses×100 > lookups×`THR_PCT`. The counts are taken over thread t's sampled-set read responses in that epoch. A rate equal to the threshold, or an epoch with no lookups, gives 0.
- R8: A lookup response counts only when it is a read (`rsp_read` = 1) to a sampled set. Write responses and responses for sets that are not sampled leave the predictor unchanged.
- R9: A response that arrives in the last cycle of an epoch counts toward the next epoch, not the one that is closing.
- R10: Each epoch starts from zero counts. A flag set by one epoch is cleared at the end of the next epoch if that epoch does not exceed the threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_read | input | 1 | 1 = read, 0 = write or writeback |
| req_thread | input | THR_W | Requesting thread |
| req_set | input | SET_W | Set index of the request |
| dirty_hit | input | 1 | Dirty tracker answer for the queried block (same cycle) |
| dirty_query | output | 1 | Dirty tracker is being asked about this request |
| tag_lookup | output | 1 | Send the request to the tag store |
| fwd_next | output | 1 | Forward the read to the next level, bypassing the tags |
| rsp_valid | input | 1 | Tag store lookup result present |
| rsp_read | input | 1 | Result belongs to a read |
| rsp_thread | input | THR_W | Thread of the looked-up request |
| rsp_set | input | SET_W | Set index of the looked-up request |
| rsp_miss | input | 1 | Lookup missed |
| bypass_flags | output | THREADS | Per-thread predicted-miss flags |

## Verification
Two things can happen in the same cycle: a lookup response arrives, and the epoch closes and the flags are re-evaluated. The bench makes this happen on purpose by driving a single sampled miss for one thread in the last cycle of the first epoch. It then expects that thread's flag to stay 0 at that boundary and to rise at the next boundary, when the carried miss is the only sample of the epoch. A second overlap is a flag change at the same edge as a predicted-miss read. The bench checks this by comparing the routing outputs against its model on every cycle, including the first cycle of each epoch.

// File: rtl/rbc_pkg.sv
package rbc_pkg;
  typedef enum logic [1:0] {
    RT_IDLE = 2'd0,
    RT_TAG  = 2'd1,
    RT_FWD  = 2'd2
  } route_e;
endpackage

// File: rtl/rbc_epoch_timer.sv
module rbc_epoch_timer #(
  parameter int EPOCH_LEN = 50_000_000
) (
  input  logic clk,
  input  logic rst_n,
  output logic epoch_last
);
  localparam int CW = (EPOCH_LEN > 1) ? $clog2(EPOCH_LEN) : 1;

  logic [CW-1:0] count_q, count_d;

  assign epoch_last = (count_q == CW'(EPOCH_LEN - 1));

  always_comb begin
    count_d = count_q;
    if (epoch_last) count_d = '0;
    else            count_d = count_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= count_d;
  end
endmodule

// File: rtl/rbc_thread_stats.sv
module rbc_thread_stats #(
  parameter int CNT_W   = 26,
  parameter int THR_PCT = 95
) (
  input  logic clk,
  input  logic rst_n,
  input  logic epoch_last,
  input  logic sample_en,
  input  logic sample_miss,
  output logic predict_miss
);
  localparam int PW = CNT_W + 7;

  logic [CNT_W-1:0] acc_q, acc_d, mis_q, mis_d;
  logic             flag_q, flag_d;
  logic [PW-1:0]    lhs, rhs;
  logic             add_acc, add_mis;

  assign add_acc = sample_en;
  assign add_mis = sample_en & sample_miss;
  assign lhs     = PW'(mis_q) * PW'(100);
  assign rhs     = PW'(acc_q) * PW'(THR_PCT);

  always_comb begin
    flag_d = flag_q;
    acc_d  = acc_q + CNT_W'(add_acc);
    mis_d  = mis_q + CNT_W'(add_mis);
    if (epoch_last) begin
      flag_d = (lhs > rhs);
      acc_d  = CNT_W'(add_acc);
      mis_d  = CNT_W'(add_mis);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      mis_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      acc_q  <= acc_d;
      mis_q  <= mis_d;
      flag_q <= flag_d;
    end
  end

  assign predict_miss = flag_q;
endmodule

// File: rtl/rbc_route.sv
module rbc_route
  import rbc_pkg::*;
#(
  parameter int THREADS   = 4,
  parameter int THR_W     = 2,
  parameter int SET_W     = 10,
  parameter int SAMP_BITS = 5
) (
  input  logic               req_valid,
  input  logic               req_read,
  input  logic [THR_W-1:0]   req_thread,
  input  logic [SET_W-1:0]   req_set,
  input  logic [THREADS-1:0] flags,
  input  logic               dirty_hit,
  output logic               dirty_query,
  output route_e             route
);
  localparam logic [SET_W-1:0] SAMP_MASK = SET_W'((1 << SAMP_BITS) - 1);

  logic sampled, predicted;

  assign sampled     = ((req_set & SAMP_MASK) == '0);
  assign predicted   = req_read & flags[req_thread] & ~sampled;
  assign dirty_query = req_valid & predicted;

  always_comb begin
    route = RT_IDLE;
    if (req_valid) begin
      if (predicted && !dirty_hit) route = RT_FWD;
      else                         route = RT_TAG;
    end
  end
endmodule

// File: rtl/rd_bypass_ctrl.sv
module rd_bypass_ctrl
  import rbc_pkg::*;
#(
  parameter int THREADS   = 4,
  parameter int SET_W     = 10,
  parameter int SAMP_BITS = 5,
  parameter int EPOCH_LEN = 50_000_000,
  parameter int THR_PCT   = 95,
  localparam int THR_W    = $clog2(THREADS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_read,
  input  logic [THR_W-1:0]   req_thread,
  input  logic [SET_W-1:0]   req_set,
  input  logic               dirty_hit,
  output logic               dirty_query,
  output logic               tag_lookup,
  output logic               fwd_next,
  input  logic               rsp_valid,
  input  logic               rsp_read,
  input  logic [THR_W-1:0]   rsp_thread,
  input  logic [SET_W-1:0]   rsp_set,
  input  logic               rsp_miss,
  output logic [THREADS-1:0] bypass_flags
);
  localparam int CNT_W = $clog2(EPOCH_LEN + 1);
  localparam logic [SET_W-1:0] SAMP_MASK = SET_W'((1 << SAMP_BITS) - 1);

  logic   epoch_last;
  logic   rsp_counts;
  route_e route;

  rbc_epoch_timer #(.EPOCH_LEN(EPOCH_LEN)) u_timer (
    .clk(clk), .rst_n(rst_n), .epoch_last(epoch_last)
  );

  assign rsp_counts = rsp_valid & rsp_read & ((rsp_set & SAMP_MASK) == '0);

  for (genvar t = 0; t < THREADS; t++) begin : g_thr
    logic hit_en;
    assign hit_en = rsp_counts & (rsp_thread == THR_W'(t));
    rbc_thread_stats #(.CNT_W(CNT_W), .THR_PCT(THR_PCT)) u_stats (
      .clk(clk), .rst_n(rst_n), .epoch_last(epoch_last),
      .sample_en(hit_en), .sample_miss(rsp_miss),
      .predict_miss(bypass_flags[t])
    );
  end

  rbc_route #(
    .THREADS(THREADS), .THR_W(THR_W), .SET_W(SET_W), .SAMP_BITS(SAMP_BITS)
  ) u_route (
    .req_valid(req_valid), .req_read(req_read), .req_thread(req_thread),
    .req_set(req_set), .flags(bypass_flags), .dirty_hit(dirty_hit),
    .dirty_query(dirty_query), .route(route)
  );

  assign tag_lookup = (route == RT_TAG);
  assign fwd_next   = (route == RT_FWD);
endmodule

// File: rtl/rbc_checker.sv
module rbc_checker #(
  parameter int THREADS   = 4,
  parameter int THR_W     = 2,
  parameter int SET_W     = 10,
  parameter int SAMP_BITS = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_read,
  input logic [THR_W-1:0]   req_thread,
  input logic [SET_W-1:0]   req_set,
  input logic               dirty_hit,
  input logic               dirty_query,
  input logic               tag_lookup,
  input logic               fwd_next,
  input logic               epoch_last,
  input logic [THREADS-1:0] bypass_flags
);
  localparam logic [SET_W-1:0] SMASK = SET_W'((1 << SAMP_BITS) - 1);

  p_unflagged_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_read && !bypass_flags[req_thread]) |-> (tag_lookup && !dirty_query && !fwd_next));

  p_query_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dirty_query |-> (req_valid && req_read && bypass_flags[req_thread]));

  p_fwd_clean_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_next |-> (!tag_lookup && dirty_query && !dirty_hit));

  p_sampled_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_read && ((req_set & SMASK) == '0)) |-> (tag_lookup && !fwd_next));

  p_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_read) |-> (tag_lookup && !dirty_query && !fwd_next));

  p_flag_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(epoch_last) |-> $stable(bypass_flags));
endmodule

bind rd_bypass_ctrl rbc_checker #(
  .THREADS(THREADS), .THR_W(THR_W), .SET_W(SET_W), .SAMP_BITS(SAMP_BITS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_read(req_read),
  .req_thread(req_thread), .req_set(req_set), .dirty_hit(dirty_hit),
  .dirty_query(dirty_query), .tag_lookup(tag_lookup), .fwd_next(fwd_next),
  .epoch_last(epoch_last), .bypass_flags(bypass_flags)
);

// File: tb/rd_bypass_ctrl_bench.sv
`timescale 1ns/1ps
module rd_bypass_ctrl_bench;
  localparam int NT = 4, SW = 6, SB = 2, EL = 64, TP = 95, TW = 2;
  localparam int NCYC = 1600;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 0, req_read = 0, dirty_hit = 0;
  logic [TW-1:0] req_thread = '0, rsp_thread = '0;
  logic [SW-1:0] req_set = '0, rsp_set = '0;
  logic rsp_valid = 0, rsp_read = 0, rsp_miss = 0;
  logic dirty_query, tag_lookup, fwd_next;
  logic [NT-1:0] bypass_flags;

  int checks = 0, errors = 0, cycles = 0;
  int m_acc[NT], m_mis[NT], m_cnt;
  bit m_flag[NT];

  always #4 clk = ~clk;

  rd_bypass_ctrl #(.THREADS(NT), .SET_W(SW), .SAMP_BITS(SB), .EPOCH_LEN(EL), .THR_PCT(TP))
  u_rd_bypass_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_read(req_read),
    .req_thread(req_thread), .req_set(req_set), .dirty_hit(dirty_hit),
    .dirty_query(dirty_query), .tag_lookup(tag_lookup), .fwd_next(fwd_next),
    .rsp_valid(rsp_valid), .rsp_read(rsp_read), .rsp_thread(rsp_thread),
    .rsp_set(rsp_set), .rsp_miss(rsp_miss), .bypass_flags(bypass_flags)
  );

  // behavioural reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0;
      for (int t = 0; t < NT; t++) begin m_acc[t] = 0; m_mis[t] = 0; m_flag[t] = 0; end
    end else begin
      if (m_cnt == EL - 1) begin
        for (int t = 0; t < NT; t++) begin
          m_flag[t] = (m_mis[t] * 100 > m_acc[t] * TP);
          m_acc[t] = 0; m_mis[t] = 0;
        end
      end
      if (rsp_valid && rsp_read && (rsp_set % (1 << SB) == 0)) begin
        m_acc[rsp_thread] += 1;
        if (rsp_miss) m_mis[rsp_thread] += 1;
      end
      m_cnt = (m_cnt == EL - 1) ? 0 : m_cnt + 1;
    end
  end

  function automatic logic [NT-1:0] model_flags();
    logic [NT-1:0] f;
    for (int t = 0; t < NT; t++) f[t] = m_flag[t];
    return f;
  endfunction

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic compare_cycle();
    bit smp, pm, eq, ef, et;
    string tg;
    smp = (req_set % (1 << SB) == 0);
    pm  = req_read && m_flag[req_thread] && !smp;
    eq  = req_valid && pm;
    ef  = req_valid && pm && !dirty_hit;
    et  = req_valid && !(pm && !dirty_hit);
    if (!req_valid || !req_read) tg = "R5";
    else if (smp) tg = "R4";
    else if (m_flag[req_thread]) tg = "R3";
    else tg = "R2";
    check(tg, "dirty_query", int'(dirty_query), int'(eq));
    check(tg, "fwd_next", int'(fwd_next), int'(ef));
    check(tg, "tag_lookup", int'(tag_lookup), int'(et));
    check("R7", "bypass_flags", int'(bypass_flags), int'(model_flags()));
  endtask

  task automatic drive(int c);
    int r;
    if (c < 256) begin
      req_valid  = (c % 7 != 6);
      req_read   = (c % 5 != 4);
      req_thread = TW'(c % 4);
      req_set    = SW'((c * 3) % 64);
      dirty_hit  = (c % 3 == 0);
      rsp_valid = 0; rsp_read = 1; rsp_miss = 0; rsp_thread = '0; rsp_set = '0;
      if (c < 20) begin
        rsp_valid = 1; rsp_thread = 0; rsp_set = SW'((c * 4) % 64); rsp_miss = 1;
      end else if (c < 40) begin
        rsp_valid = 1; rsp_thread = 1; rsp_set = SW'((c * 4) % 64); rsp_miss = (c != 20);
      end else if (c < 60) begin
        rsp_valid = 1; rsp_thread = 2; rsp_set = SW'((c * 4 + 1) % 64); rsp_miss = 1; // R8 unsampled
      end else if (c < 63) begin
        rsp_valid = 1; rsp_thread = 2; rsp_set = '0; rsp_miss = 1; rsp_read = 0;     // R8 writes
      end else if (c == 63) begin
        rsp_valid = 1; rsp_thread = 3; rsp_set = SW'(8); rsp_miss = 1;             // R9 boundary
      end
    end else begin
      req_valid  = ($urandom % 8 != 0);
      req_read   = ($urandom % 4 != 0);
      req_thread = TW'($urandom % 4);
      req_set    = SW'($urandom % 64);
      dirty_hit  = $urandom % 2;
      rsp_valid  = $urandom % 2;
      rsp_read   = ($urandom % 6 != 0);
      rsp_thread = TW'($urandom % 4);
      rsp_set    = SW'(($urandom % 3 == 0) ? $urandom % 64 : ($urandom % 16) * 4);
      r = $urandom % 100;
      case (rsp_thread)
        2'd0: rsp_miss = 1;
        2'd1: rsp_miss = (r < 97);
        2'd2: rsp_miss = (r < 50);
        default: rsp_miss = (r < 93);
      endcase
    end
  endtask

  initial begin : watchdog
    while (cycles < 200000) begin @(posedge clk); cycles++; end
    errors++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    req_valid = 1; req_read = 1; req_thread = 0; req_set = SW'(5); dirty_hit = 0;
    rsp_valid = 1; rsp_read = 1; rsp_set = '0; rsp_miss = 1;
    @(posedge clk); #2;
    check("R1", "bypass_flags in reset", int'(bypass_flags), 0);
    check("R1", "fwd_next in reset", int'(fwd_next), 0);
    check("R1", "dirty_query in reset", int'(dirty_query), 0);
    check("R1", "tag_lookup in reset", int'(tag_lookup), 1);
    @(negedge clk);
    rst_n = 1;
    for (int c = 0; c < NCYC; c++) begin
      if (c > 0) @(negedge clk);
      drive(c);
      #2;
      compare_cycle();
      if (c == 63) check("R6", "flags before first boundary", int'(bypass_flags), 0);
      if (c == 64) begin
        check("R7", "t0 all-miss flag", int'(bypass_flags[0]), 1);
        check("R7", "t1 rate equal to threshold", int'(bypass_flags[1]), 0);
        check("R8", "t2 only unsampled/write responses", int'(bypass_flags[2]), 0);
        check("R9", "t3 boundary miss not in closing epoch", int'(bypass_flags[3]), 0);
      end
      if (c == 127) check("R6", "flags held inside epoch", int'(bypass_flags), 1);
      if (c == 128) begin
        check("R9", "t3 carried miss sets flag", int'(bypass_flags[3]), 1);
        check("R10", "t0 flag cleared by empty epoch", int'(bypass_flags[0]), 0);
      end
      if (c == 192) check("R10", "all flags cleared", int'(bypass_flags), 0);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule